// File: doc/BRIEF.md
# Audio Codec Interrupt and DMA Request Logic

This block sits beside the audio stream converter and its two word FIFOs. It turns the converter's status into one interrupt line and four DMA request lines. Two of the interrupt sources are events: a new output sample has been written, or an input sample has been consumed. These are caught in sticky pending bits that software clears by writing ones. The other four sources are levels taken straight from the FIFOs: inbound nearly empty, outbound nearly full, inbound empty and outbound full. Three enables gate these six sources. The PCM enable covers both pending bits, the warning enable covers both nearly-limit flags, and the error enable covers both hard-limit flags.

Each DMA channel moves a single word, and the controller does the transfer indirectly. Two channels follow the state of a holding register: the output register is full, or the input register is empty. The other two channels latch a FIFO event: a word was pushed into the outbound FIFO, or a word was drained from the inbound FIFO. A request stays up until the controller acknowledges it. It then drops for one cycle, so the controller can tell one transfer from the next.

Top module: `codec_req_ctrl`

## Requirements
- R1: After reset, `irq`, every bit of `dma_req` and both bits of `pcm_pend` are 0.
- R2: `pcm_pend[0]` is set by `pcm_out_wr_stb` and `pcm_pend[1]` by `pcm_in_rd_stb`. Each bit stays set until a 1 is written on the matching bit of `pend_clr`. When a set and a clear meet in the same cycle, the set wins.
- R3: When `pcm_ie` is 1, `irq` goes high on the clock edge where either pending bit becomes or stays set.
- R4: When `warn_ie` is 1, `irq` goes high one cycle after `in_near_empty` or `out_near_full` is 1.
- R5: When `err_ie` is 1, `irq` goes high one cycle after `in_empty` or `out_full` is 1.
- R6: A source whose enable is 0 has no effect on `irq`. The pending bits still record events while `pcm_ie` is 0.
- R7: Channel 0 (`dma_en[0]`) is the output-sample channel. Its request goes high one cycle after `dma_en[0]` and `pcm_out_full` are both 1, and falls one cycle after either of them drops.
- R8: Channel 1 (`dma_en[1]`) is the input-sample channel. It follows `dma_en[1]` and `pcm_in_empty` in the same way as R7.
- R9: Channel 2 latches `strm_out_push` and channel 3 latches `strm_in_pop`. Each requests one cycle after its strobe and holds the request until it is acknowledged, even after the strobe has gone.
- R10: A request that sees its `dma_ack` bit on a clock edge is low for the next cycle. An acknowledge that arrives while the request is low is ignored. If a level condition is still true after the low cycle, the request rises again. If a new strobe arrives in the same cycle as the acknowledge, it produces a fresh request after the low cycle.
- R11: When a `dma_en` bit is 0, its request is low one cycle later. An event that an event channel has latched but not yet had acknowledged is kept, and it requests again once the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pcm_ie | input | 1 | Enables the two pending sample events |
| warn_ie | input | 1 | Enables the nearly-empty and nearly-full flags |
| err_ie | input | 1 | Enables the empty and full flags |
| pcm_out_wr_stb | input | 1 | Pulse: new output sample written |
| pcm_in_rd_stb | input | 1 | Pulse: input sample consumed |
| pend_clr | input | 2 | Write-one-to-clear for `pcm_pend` |
| in_near_empty | input | 1 | Inbound FIFO nearly empty |
| out_near_full | input | 1 | Outbound FIFO nearly full |
| in_empty | input | 1 | Inbound FIFO empty |
| out_full | input | 1 | Outbound FIFO full |
| pcm_out_full | input | 1 | Output holding register holds an unread sample |
| pcm_in_empty | input | 1 | Input holding register is free |
| strm_out_push | input | 1 | Pulse: word entered the outbound FIFO |
| strm_in_pop | input | 1 | Pulse: word drained from the inbound FIFO |
| dma_en | input | 4 | Per-channel DMA enable |
| dma_ack | input | 4 | Per-channel DMA acknowledge |
| irq | output | 1 | Interrupt request |
| dma_req | output | 4 | Per-channel DMA request |
| pcm_pend | output | 2 | Sticky pending sample events |

## Verification
Several properties are checked on every cycle. A request is never raised without its enable on the edge before. An acknowledged request always drops. A latched event request holds until it is acknowledged. Each holding-register channel follows its condition. A pending bit sets on its strobe and holds until cleared. The interrupt fires only when some enable was set and always fires for an enabled error flag. Other behaviours need the bench's ordered scenarios. These are the set-over-clear priority, a strobe that arrives together with an acknowledge and gives a second request, an event kept across a disabled window, and each disabled source leaving `irq` low.

// File: rtl/codec_req_pkg.sv
package codec_req_pkg;
    localparam int NUM_PEND = 2;
    localparam int NUM_PAIR = 2;
    localparam int NUM_DMA  = 4;

    localparam int CH_PCM_OUT = 0;
    localparam int CH_PCM_IN  = 1;
    localparam int CH_STR_OUT = 2;
    localparam int CH_STR_IN  = 3;

    typedef struct packed {
        logic                irq;
        logic [NUM_PEND-1:0] pend;
    } irq_state_t;

    typedef struct packed {
        logic req;
        logic evt;
    } chan_state_t;
endpackage

// File: rtl/codec_irq_merge.sv
module codec_irq_merge
    import codec_req_pkg::*;
#(
    parameter int N_PEND = NUM_PEND,
    parameter int N_PAIR = NUM_PAIR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pcm_ie,
    input  logic              warn_ie,
    input  logic              err_ie,
    input  logic [N_PEND-1:0] pend_set,
    input  logic [N_PEND-1:0] pend_clr,
    input  logic [N_PAIR-1:0] warn_src,
    input  logic [N_PAIR-1:0] err_src,
    output logic              irq,
    output logic [N_PEND-1:0] pend
);
    typedef struct packed {
        logic              irq;
        logic [N_PEND-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new event beats a clear arriving in the same cycle
        st_d.pend = (st_q.pend & ~pend_clr) | pend_set;
        st_d.irq  = (pcm_ie  & (|st_d.pend))
                  | (warn_ie & (|warn_src))
                  | (err_ie  & (|err_src));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq  = st_q.irq;
    assign pend = st_q.pend;
endmodule

// File: rtl/codec_dma_chan.sv
module codec_dma_chan
    import codec_req_pkg::*;
#(
    parameter bit IS_EVENT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl,
    input  logic stb,
    input  logic ack,
    output logic req
);
    chan_state_t st_d, st_q;
    logic        taken;
    logic        cond;

    always_comb begin
        st_d  = st_q;
        taken = st_q.req & ack;
        if (IS_EVENT) begin
            st_d.evt = stb | (st_q.evt & ~taken);
            cond     = st_d.evt;
        end else begin
            st_d.evt = 1'b0;
            cond     = lvl;
        end
        // an accepted request always takes one low cycle
        st_d.req = en & cond & ~taken;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;
endmodule

// File: rtl/codec_req_ctrl.sv
module codec_req_ctrl
    import codec_req_pkg::*;
#(
    parameter int               N_DMA    = NUM_DMA,
    parameter logic [N_DMA-1:0] EVT_MASK = 4'b1100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pcm_ie,
    input  logic             warn_ie,
    input  logic             err_ie,
    input  logic             pcm_out_wr_stb,
    input  logic             pcm_in_rd_stb,
    input  logic [1:0]       pend_clr,
    input  logic             in_near_empty,
    input  logic             out_near_full,
    input  logic             in_empty,
    input  logic             out_full,
    input  logic             pcm_out_full,
    input  logic             pcm_in_empty,
    input  logic             strm_out_push,
    input  logic             strm_in_pop,
    input  logic [N_DMA-1:0] dma_en,
    input  logic [N_DMA-1:0] dma_ack,
    output logic             irq,
    output logic [N_DMA-1:0] dma_req,
    output logic [1:0]       pcm_pend
);
    logic [N_DMA-1:0] chan_lvl;
    logic [N_DMA-1:0] chan_stb;

    always_comb begin
        chan_lvl             = '0;
        chan_stb             = '0;
        chan_lvl[CH_PCM_OUT] = pcm_out_full;
        chan_lvl[CH_PCM_IN]  = pcm_in_empty;
        chan_stb[CH_STR_OUT] = strm_out_push;
        chan_stb[CH_STR_IN]  = strm_in_pop;
    end

    codec_irq_merge #(
        .N_PEND (2),
        .N_PAIR (2)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pcm_ie   (pcm_ie),
        .warn_ie  (warn_ie),
        .err_ie   (err_ie),
        .pend_set ({pcm_in_rd_stb, pcm_out_wr_stb}),
        .pend_clr (pend_clr),
        .warn_src ({out_near_full, in_near_empty}),
        .err_src  ({out_full, in_empty}),
        .irq      (irq),
        .pend     (pcm_pend)
    );

    for (genvar ch = 0; ch < N_DMA; ch++) begin : g_chan
        codec_dma_chan #(
            .IS_EVENT (EVT_MASK[ch])
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (dma_en[ch]),
            .lvl   (chan_lvl[ch]),
            .stb   (chan_stb[ch]),
            .ack   (dma_ack[ch]),
            .req   (dma_req[ch])
        );
    end
endmodule

// File: rtl/codec_req_ctrl_chk.sv
module codec_req_ctrl_chk #(
    parameter int               N_DMA    = 4,
    parameter logic [N_DMA-1:0] EVT_MASK = 4'b1100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pcm_ie,
    input logic             warn_ie,
    input logic             err_ie,
    input logic             pcm_out_wr_stb,
    input logic [1:0]       pend_clr,
    input logic             in_empty,
    input logic             pcm_out_full,
    input logic             pcm_in_empty,
    input logic [N_DMA-1:0] dma_en,
    input logic [N_DMA-1:0] dma_ack,
    input logic             irq,
    input logic [N_DMA-1:0] dma_req,
    input logic [1:0]       pcm_pend
);
    for (genvar ch = 0; ch < N_DMA; ch++) begin : g_chk
        AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            dma_req[ch] |-> $past(dma_en[ch])); // R11
        AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_req[ch] && dma_ack[ch]) |=> !dma_req[ch]); // R10
        if (EVT_MASK[ch]) begin : g_evt
            AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (dma_req[ch] && !dma_ack[ch] && dma_en[ch]) |=> dma_req[ch]); // R9
        end
    end

    AST_PCM_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en[0] && pcm_out_full && !(dma_req[0] && dma_ack[0])) |=> dma_req[0]); // R7
    AST_PCM_IN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en[1] && pcm_in_empty && !(dma_req[1] && dma_ack[1])) |=> dma_req[1]); // R8
    AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_out_wr_stb |=> pcm_pend[0]); // R2
    AST_PEND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_pend[0] && !pend_clr[0]) |=> pcm_pend[0]); // R2
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(pcm_ie || warn_ie || err_ie)); // R6
    AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ie && in_empty) |=> irq); // R5
endmodule

bind codec_req_ctrl codec_req_ctrl_chk #(
    .N_DMA    (N_DMA),
    .EVT_MASK (EVT_MASK)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pcm_ie         (pcm_ie),
    .warn_ie        (warn_ie),
    .err_ie         (err_ie),
    .pcm_out_wr_stb (pcm_out_wr_stb),
    .pend_clr       (pend_clr),
    .in_empty       (in_empty),
    .pcm_out_full   (pcm_out_full),
    .pcm_in_empty   (pcm_in_empty),
    .dma_en         (dma_en),
    .dma_ack        (dma_ack),
    .irq            (irq),
    .dma_req        (dma_req),
    .pcm_pend       (pcm_pend)
);

// File: tb/codec_req_ctrl_test.sv
module codec_req_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pcm_ie = 0, warn_ie = 0, err_ie = 0;
    logic       pcm_out_wr_stb = 0, pcm_in_rd_stb = 0;
    logic [1:0] pend_clr = '0;
    logic       in_near_empty = 0, out_near_full = 0, in_empty = 0, out_full = 0;
    logic       pcm_out_full = 0, pcm_in_empty = 0;
    logic       strm_out_push = 0, strm_in_pop = 0;
    logic [3:0] dma_en = '0, dma_ack = '0;
    logic       irq;
    logic [3:0] dma_req;
    logic [1:0] pcm_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic       irq;
        logic [3:0] req;
        logic [1:0] pend;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    codec_req_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pcm_ie(pcm_ie), .warn_ie(warn_ie), .err_ie(err_ie),
        .pcm_out_wr_stb(pcm_out_wr_stb), .pcm_in_rd_stb(pcm_in_rd_stb), .pend_clr(pend_clr),
        .in_near_empty(in_near_empty), .out_near_full(out_near_full), .in_empty(in_empty),
        .out_full(out_full), .pcm_out_full(pcm_out_full), .pcm_in_empty(pcm_in_empty),
        .strm_out_push(strm_out_push), .strm_in_pop(strm_in_pop), .dma_en(dma_en),
        .dma_ack(dma_ack), .irq(irq), .dma_req(dma_req), .pcm_pend(pcm_pend)
    );

    // driver: one clock edge, then queue what the outputs must show after it
    task automatic cyc(input logic e_irq, input logic [3:0] e_req,
                       input logic [1:0] e_pend, input string tag);
        exp_t e;
        @(posedge clk);
        #2;
        e.irq = e_irq; e.req = e_req; e.pend = e_pend; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare at the falling edge after each queued rising edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (irq !== e.irq || dma_req !== e.req || pcm_pend !== e.pend) begin
                errors++;
                $display("FAIL %s: irq=%b req=%b pend=%b, expected irq=%b req=%b pend=%b",
                         e.tag, irq, dma_req, pcm_pend, e.irq, e.req, e.pend);
            end
        end
    end

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cyc(0, 4'b0000, 2'b00, "R1 reset state");

        // pending bits and PCM interrupt
        pcm_out_wr_stb = 1;
        cyc(0, 4'b0000, 2'b01, "R6 pcm disabled, R2 set");
        pcm_out_wr_stb = 0;
        cyc(0, 4'b0000, 2'b01, "R2 pending holds");
        pcm_ie = 1;
        cyc(1, 4'b0000, 2'b01, "R3 pcm irq");
        pend_clr = 2'b01;
        cyc(0, 4'b0000, 2'b00, "R2 write-one clear");
        pcm_in_rd_stb = 1; pend_clr = 2'b10;
        cyc(1, 4'b0000, 2'b10, "R2 set beats clear");
        pcm_in_rd_stb = 0;
        cyc(0, 4'b0000, 2'b00, "R2 clear bit1");
        pend_clr = 2'b00; pcm_ie = 0;

        // warning sources
        warn_ie = 1; in_near_empty = 1;
        cyc(1, 4'b0000, 2'b00, "R4 nearly empty");
        in_near_empty = 0; out_near_full = 1;
        cyc(1, 4'b0000, 2'b00, "R4 nearly full");
        warn_ie = 0;
        cyc(0, 4'b0000, 2'b00, "R6 warning disabled");
        out_near_full = 0;

        // error sources
        err_ie = 1; in_empty = 1;
        cyc(1, 4'b0000, 2'b00, "R5 inbound empty");
        in_empty = 0; out_full = 1;
        cyc(1, 4'b0000, 2'b00, "R5 outbound full");
        err_ie = 0;
        cyc(0, 4'b0000, 2'b00, "R6 error disabled");
        out_full = 0;

        // output-sample channel
        pcm_out_full = 1;
        cyc(0, 4'b0000, 2'b00, "R11 channel 0 disabled");
        dma_en = 4'b0001;
        cyc(0, 4'b0001, 2'b00, "R7 request");
        dma_ack = 4'b0001;
        cyc(0, 4'b0000, 2'b00, "R10 low after ack");
        dma_ack = 4'b0000;
        cyc(0, 4'b0001, 2'b00, "R10 re-request while full");
        pcm_out_full = 0;
        cyc(0, 4'b0000, 2'b00, "R7 drops when drained");

        // input-sample channel, stray ack ignored
        dma_en = 4'b0010; dma_ack = 4'b0010;
        cyc(0, 4'b0000, 2'b00, "R10 ack without request");
        dma_ack = 4'b0000; pcm_in_empty = 1;
        cyc(0, 4'b0010, 2'b00, "R8 request");
        pcm_in_empty = 0;
        cyc(0, 4'b0000, 2'b00, "R8 drops when filled");

        // event channels
        dma_en = 4'b1100; strm_out_push = 1;
        cyc(0, 4'b0100, 2'b00, "R9 push latched");
        strm_out_push = 0;
        cyc(0, 4'b0100, 2'b00, "R9 held");
        cyc(0, 4'b0100, 2'b00, "R9 still held");
        dma_ack = 4'b0100;
        cyc(0, 4'b0000, 2'b00, "R10 ack clears event");
        dma_ack = 4'b0000;
        cyc(0, 4'b0000, 2'b00, "R9 event consumed");
        strm_in_pop = 1;
        cyc(0, 4'b1000, 2'b00, "R9 pop latched");
        dma_ack = 4'b1000;
        cyc(0, 4'b0000, 2'b00, "R10 ack with new strobe");
        dma_ack = 4'b0000; strm_in_pop = 0;
        cyc(0, 4'b1000, 2'b00, "R10 fresh request");
        dma_ack = 4'b1000;
        cyc(0, 4'b0000, 2'b00, "R10 second ack");
        dma_ack = 4'b0000;
        cyc(0, 4'b0000, 2'b00, "R9 nothing left");

        // enable removed with an event outstanding
        strm_out_push = 1;
        cyc(0, 4'b0100, 2'b00, "R9 push again");
        strm_out_push = 0; dma_en = 4'b1000;
        cyc(0, 4'b0000, 2'b00, "R11 disable drops request");
        dma_en = 4'b1100;
        cyc(0, 4'b0100, 2'b00, "R11 event kept");
        dma_ack = 4'b0100;
        cyc(0, 4'b0000, 2'b00, "R11 ack after re-enable");
        dma_ack = 4'b0000;

        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule